// File: doc/BRIEF.md
# Neighbour Core Mailbox Link

This block joins two adjacent processor cores with a pair of one-word mailboxes, one for each direction. The core on the lower side deposits words that the upper core picks up, and the upper core does the same in the other direction. Each core sees one link toward the core below it and one toward the core above it, so its lower/upper select amounts to choosing which link instance its strobes go to. Instruction decode and register-file moves stay in the cores. The link itself sees only plain write and read strobes and returns status flags.

A writer can ask for a guarded deposit. The guarded form is taken only when the previous word has been released by the reader, and the writer learns in the same cycle, through an acknowledge flag, whether the word was taken. A plain deposit always lands, even over a word that has not been read. A reader may look at the word as often as it likes. A freshness flag tells it whether this is the first look since the last deposit, and a release flag sent with a look frees the slot for the writer. Every accepted deposit sends a one-cycle interrupt pulse toward the reader. Guarded deposits together with releases give a lossless single-word handshake that needs no shared-memory arbitration.

Top module: `nbrMailboxLink`

## Requirements
- R1: After reset every mailbox holds zero and counts as released: a look returns data 0 with freshness 0, no interrupt is raised, and the first guarded deposit is accepted.
- R2: An accepted deposit is returned as read data from the cycle that follows its clock edge onward, and stays there until the next accepted deposit.
- R3: The freshness flag is 1 on the first look after an accepted deposit and 0 on every later look at the same word. Outside a look it reads 0.
- R4: A guarded deposit (`WrCond`=1) into an unreleased mailbox, with no release in the same cycle, returns write acknowledge 0, leaves the stored word unchanged and raises no interrupt.
- R5: A look with release (`RdEn`=1, `RdAck`=1) frees the mailbox, so a later guarded deposit is accepted with acknowledge 1.
- R6: A look without release leaves the mailbox unreleased, so a later guarded deposit is still refused.
- R7: A plain deposit (`WrCond`=0) is always accepted. It replaces the word and sets freshness again, even when the old word was never looked at.
- R8: The reader's interrupt is 1 for exactly the one cycle after each accepted deposit and 0 otherwise.
- R9: A guarded deposit and a release in the same cycle on an unreleased mailbox: the release is applied first, so the deposit is accepted. The look in that cycle still returns the old word.
- R10: The two directions are independent. A deposit by one side changes only the data, freshness and interrupt seen by the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loWrEn | input | 1 | Lower core deposit strobe |
| loWrCond | input | 1 | Lower core deposit is guarded |
| loWrData | input | DATA_W | Lower core deposit word |
| loWrAck | output | 1 | Lower core deposit accepted (same cycle) |
| loRdEn | input | 1 | Lower core look strobe |
| loRdAck | input | 1 | Lower core releases the word it looks at |
| loRdData | output | DATA_W | Word deposited by the upper core |
| loRdNew | output | 1 | First look since the last deposit |
| loIrq | output | 1 | Deposit arrived from the upper core |
| hiWrEn | input | 1 | Upper core deposit strobe |
| hiWrCond | input | 1 | Upper core deposit is guarded |
| hiWrData | input | DATA_W | Upper core deposit word |
| hiWrAck | output | 1 | Upper core deposit accepted (same cycle) |
| hiRdEn | input | 1 | Upper core look strobe |
| hiRdAck | input | 1 | Upper core releases the word it looks at |
| hiRdData | output | DATA_W | Word deposited by the lower core |
| hiRdNew | output | 1 | First look since the last deposit |
| hiIrq | output | 1 | Deposit arrived from the lower core |

## Verification
The bench aims at the slot-full boundary. It tries guarded deposits with and without a release in the same cycle: a design that ordered the release after the deposit would refuse a word it should take, and one that ignored the full state would silently lose data. It looks repeatedly at one word and makes plain deposits over unread words, which catches a freshness flag that fails to clear or fails to set again. It also checks that the interrupt lasts exactly one cycle and that traffic in one direction never leaks into the other, which catches swapped or shared wiring between the two mailboxes.

// File: rtl/nbr_mbox_pkg.sv
package nbr_mbox_pkg;
  // Strobes the control half sends to the datapath half of one mailbox.
  typedef struct packed {
    logic load;   // capture the deposit word
  } mboxStrb_t;

  localparam int SIDES = 2;  // lower side index 0, upper side index 1
endpackage

// File: rtl/mboxCtrl.sv
module mboxCtrl
  import nbr_mbox_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrCond,
  input  logic      rdEn,
  input  logic      rdAck,
  output logic      wrAck,
  output logic      rdNew,
  output logic      irq,
  output mboxStrb_t strb
);
  logic full;      // word deposited and not yet released
  logic fresh;     // word not yet looked at
  logic relNow;
  logic accept;

  // A release in this cycle frees the slot before the deposit is judged.
  assign relNow = rdEn & rdAck;
  assign accept = wrEn & (~wrCond | ~full | relNow);

  assign wrAck     = accept;
  assign rdNew     = rdEn & fresh;
  assign strb.load = accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      full  <= 1'b0;
      fresh <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= accept;
      if (accept)      full <= 1'b1;
      else if (relNow) full <= 1'b0;
      if (accept)      fresh <= 1'b1;
      else if (rdEn)   fresh <= 1'b0;
    end
  end

  // R6: without a release and without a deposit the slot stays occupied
  p_hold_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    full && !relNow && !accept |=> full);
  // R4: a guarded deposit into an occupied slot without release is refused
  p_refuse_guarded_r4: assert property (@(posedge clk) disable iff (!rstN)
    full && !relNow && wrEn && wrCond |-> !wrAck);
  // R8: interrupt follows every accepted deposit
  p_irq_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrAck |=> irq);
  // R8: no interrupt without a deposit in the cycle before
  p_irq_only_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrAck |=> !irq);
  // R3: a look with no deposit leaves the word stale
  p_fresh_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !wrAck |=> !fresh);
  // R7: a plain deposit is never refused
  p_plain_accepted_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !wrCond |-> wrAck);
endmodule

// File: rtl/mboxData.sv
module mboxData
  import nbr_mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk) begin
    if (!rstN)          word <= '0;
    else if (strb.load) word <= wrData;
  end

  assign rdData = word;

  // R2: the captured word is the one presented with the load strobe
  p_load_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> rdData == $past(wrData));
  // R4: without a load the word does not move
  p_word_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(rdData));
endmodule

// File: rtl/mboxLatch.sv
module mboxLatch
  import nbr_mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrCond,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrAck,
  input  logic              rdEn,
  input  logic              rdAck,
  output logic [DATA_W-1:0] rdData,
  output logic              rdNew,
  output logic              irq
);
  mboxStrb_t strb;

  mboxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCond(wrCond),
    .rdEn(rdEn), .rdAck(rdAck), .wrAck(wrAck), .rdNew(rdNew),
    .irq(irq), .strb(strb)
  );

  mboxData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/nbrMailboxLink.sv
module nbrMailboxLink
  import nbr_mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loWrEn,
  input  logic              loWrCond,
  input  logic [DATA_W-1:0] loWrData,
  output logic              loWrAck,
  input  logic              loRdEn,
  input  logic              loRdAck,
  output logic [DATA_W-1:0] loRdData,
  output logic              loRdNew,
  output logic              loIrq,
  input  logic              hiWrEn,
  input  logic              hiWrCond,
  input  logic [DATA_W-1:0] hiWrData,
  output logic              hiWrAck,
  input  logic              hiRdEn,
  input  logic              hiRdAck,
  output logic [DATA_W-1:0] hiRdData,
  output logic              hiRdNew,
  output logic              hiIrq
);
  // Per-side vectors, index = side (0 lower, 1 upper).
  logic [SIDES-1:0]  wrEnS, wrCondS, wrAckS, rdEnS, rdAckS, rdNewS, irqS;
  logic [DATA_W-1:0] wrDataS [SIDES];
  logic [DATA_W-1:0] rdDataS [SIDES];

  assign wrEnS   = {hiWrEn, loWrEn};
  assign wrCondS = {hiWrCond, loWrCond};
  assign rdEnS   = {hiRdEn, loRdEn};
  assign rdAckS  = {hiRdAck, loRdAck};
  assign wrDataS[0] = loWrData;
  assign wrDataS[1] = hiWrData;

  // Mailbox d is written by side d and read by the opposite side.
  for (genvar d = 0; d < SIDES; d++) begin : g_dir
    localparam int RD = SIDES - 1 - d;
    mboxLatch #(.DATA_W(DATA_W)) u_latch (
      .clk(clk), .rstN(rstN),
      .wrEn(wrEnS[d]), .wrCond(wrCondS[d]), .wrData(wrDataS[d]),
      .wrAck(wrAckS[d]),
      .rdEn(rdEnS[RD]), .rdAck(rdAckS[RD]),
      .rdData(rdDataS[RD]), .rdNew(rdNewS[RD]), .irq(irqS[RD])
    );
  end

  assign loWrAck  = wrAckS[0];
  assign hiWrAck  = wrAckS[1];
  assign loRdData = rdDataS[0];
  assign hiRdData = rdDataS[1];
  assign loRdNew  = rdNewS[0];
  assign hiRdNew  = rdNewS[1];
  assign loIrq    = irqS[0];
  assign hiIrq    = irqS[1];

  // R10: a deposit from the lower side never disturbs what the lower side reads
  p_dir_isolated_r10: assert property (@(posedge clk) disable iff (!rstN)
    !hiWrAck |=> $stable(loRdData));
  // R10: and likewise for the upper side
  p_dir_isolated_hi_r10: assert property (@(posedge clk) disable iff (!rstN)
    !loWrAck |=> $stable(hiRdData));
endmodule

// File: tb/nbrMailboxLink_bench.sv
module nbrMailboxLink_bench;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Stimulus per side (0 lower, 1 upper)
  logic              wrEn [2], wrCond [2], rdEn [2], rdAck [2];
  logic [DATA_W-1:0] wrData [2];
  logic              wrAckO [2], rdNewO [2], irqO [2];
  logic [DATA_W-1:0] rdDataO [2];

  nbrMailboxLink #(.DATA_W(DATA_W)) u_nbrMailboxLink (
    .clk(clk), .rstN(rstN),
    .loWrEn(wrEn[0]), .loWrCond(wrCond[0]), .loWrData(wrData[0]), .loWrAck(wrAckO[0]),
    .loRdEn(rdEn[0]), .loRdAck(rdAck[0]), .loRdData(rdDataO[0]), .loRdNew(rdNewO[0]),
    .loIrq(irqO[0]),
    .hiWrEn(wrEn[1]), .hiWrCond(wrCond[1]), .hiWrData(wrData[1]), .hiWrAck(wrAckO[1]),
    .hiRdEn(rdEn[1]), .hiRdAck(rdAck[1]), .hiRdData(rdDataO[1]), .hiRdNew(rdNewO[1]),
    .hiIrq(irqO[1])
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Model per mailbox d (written by side d, read by side 1-d)
  logic              mFull [2], mFresh [2], mIrq [2];
  logic [DATA_W-1:0] mWord [2];

  function automatic logic expAccept(int d);
    return wrEn[d] && (!wrCond[d] || !mFull[d] || (rdEn[1-d] && rdAck[1-d]));
  endfunction

  function automatic string ackTag(int d);
    if (!wrCond[d]) return "R7";
    if (!mFull[d]) return "R5";
    if (rdEn[1-d] && rdAck[1-d]) return "R9";
    return "R4";
  endfunction

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    for (int s = 0; s < 2; s++) begin
      wrEn[s] = 0; wrCond[s] = 0; rdEn[s] = 0; rdAck[s] = 0; wrData[s] = '0;
    end
  endtask

  task automatic modelReset();
    for (int d = 0; d < 2; d++) begin
      mFull[d] = 0; mFresh[d] = 0; mIrq[d] = 0; mWord[d] = '0;
    end
  endtask

  // Inputs are set by the caller after a negedge; check outputs, then advance.
  task automatic stepCheck();
    logic acc [2];
    #1;
    for (int d = 0; d < 2; d++) begin
      int r = 1 - d;
      acc[d] = expAccept(d);
      if (wrEn[d]) chk(ackTag(d), {31'b0, wrAckO[d]}, {31'b0, acc[d]});
      chk("R2", rdDataO[r], mWord[d]);
      chk("R3", {31'b0, rdNewO[r]}, {31'b0, rdEn[r] & mFresh[d]});
      chk("R8", {31'b0, irqO[r]}, {31'b0, mIrq[d]});
    end
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      int r = 1 - d;
      mIrq[d] = acc[d];
      if (acc[d]) begin
        mWord[d] = wrData[d]; mFull[d] = 1; mFresh[d] = 1;
      end else begin
        if (rdEn[r] && rdAck[r]) mFull[d] = 0;
        if (rdEn[r]) mFresh[d] = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic doWrite(int s, logic cond, logic [DATA_W-1:0] v);
    idle(); wrEn[s] = 1; wrCond[s] = cond; wrData[s] = v; stepCheck();
  endtask

  task automatic doRead(int s, logic ack);
    idle(); rdEn[s] = 1; rdAck[s] = ack; stepCheck();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    modelReset();
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state seen at the ports
    idle(); rdEn[0] = 1; rdEn[1] = 1; #1;
    chk("R1", rdDataO[0], '0);
    chk("R1", rdDataO[1], '0);
    chk("R1", {31'b0, rdNewO[0] | rdNewO[1]}, '0);
    chk("R1", {31'b0, irqO[0] | irqO[1]}, '0);
    @(negedge clk);
    // R1: first guarded deposit accepted
    idle(); wrEn[0] = 1; wrCond[0] = 1; wrData[0] = 32'hA5A5_0001; #1;
    chk("R1", {31'b0, wrAckO[0]}, 1'b1);
    @(negedge clk);
    mWord[0] = 32'hA5A5_0001; mFull[0] = 1; mFresh[0] = 1; mIrq[0] = 1;
    // R8 interrupt toward the upper side, R2 data visible, R10 no leakage
    idle(); #1;
    chk("R8", {31'b0, irqO[1]}, 1'b1);
    chk("R2", rdDataO[1], 32'hA5A5_0001);
    chk("R10", rdDataO[0], '0);
    chk("R10", {31'b0, irqO[0]}, '0);
    @(negedge clk);
    mIrq[0] = 0;
    // R3: first look fresh, second not
    doRead(1, 0);
    idle(); rdEn[1] = 1; #1;
    chk("R3", {31'b0, rdNewO[1]}, 1'b0);
    @(negedge clk);
    // R6: look without release keeps slot occupied
    idle(); wrEn[0] = 1; wrCond[0] = 1; wrData[0] = 32'h1111_2222; #1;
    chk("R6", {31'b0, wrAckO[0]}, 1'b0);
    @(negedge clk);
    idle(); #1;
    chk("R4", rdDataO[1], 32'hA5A5_0001);
    chk("R4", {31'b0, irqO[1]}, 1'b0);
    @(negedge clk);
    // R9: release and guarded deposit in same cycle
    idle(); rdEn[1] = 1; rdAck[1] = 1;
    wrEn[0] = 1; wrCond[0] = 1; wrData[0] = 32'h3333_4444; #1;
    chk("R9", {31'b0, wrAckO[0]}, 1'b1);
    chk("R9", rdDataO[1], 32'hA5A5_0001);
    @(negedge clk);
    mWord[0] = 32'h3333_4444; mFull[0] = 1; mFresh[0] = 1; mIrq[0] = 1;
    // R7: plain deposit over unread word, freshness set again
    doWrite(0, 0, 32'h5555_6666);
    doRead(1, 0);
    doWrite(0, 0, 32'h7777_8888);
    idle(); rdEn[1] = 1; #1;
    chk("R7", {31'b0, rdNewO[1]}, 1'b1);
    chk("R7", rdDataO[1], 32'h7777_8888);
    @(negedge clk);
    mFresh[0] = 0; mIrq[0] = 0;
    // R5: release then guarded deposit accepted
    doRead(1, 1);
    idle(); wrEn[0] = 1; wrCond[0] = 1; wrData[0] = 32'h9999_0000; #1;
    chk("R5", {31'b0, wrAckO[0]}, 1'b1);
    stepCheck();
    // Upper-to-lower direction, directed then random traffic on both
    doWrite(1, 1, 32'hCAFE_0001);
    doWrite(1, 1, 32'hCAFE_0002);
    doRead(0, 1);
    doWrite(1, 1, 32'hCAFE_0003);
    for (int i = 0; i < 3000; i++) begin
      for (int s = 0; s < 2; s++) begin
        wrEn[s]   = ($urandom % 3) == 0;
        wrCond[s] = ($urandom % 4) != 0;
        wrData[s] = $urandom;
        rdEn[s]   = ($urandom % 2) == 0;
        rdAck[s]  = ($urandom % 3) == 0;
      end
      stepCheck();
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule